// File: doc/BRIEF.md
# Block-Addressed Dual-Clock Field Store

This block is a word-serial field store. Each word is 12 bits wide. It has a write port and a read port, and each port runs from its own clock with its own enable and pointer-restart controls. Writes and reads therefore proceed at independent rates. Every enabled clock moves exactly one word and steps the port's address pointer by one. The pointer wraps back to the first address after the last one. In steady operation the store acts as a fixed delay line. Because reading never consumes data, one written field can also be read back several times, which multiplies the output rate.

Storage is organised as a parameterised number of fixed 40-word blocks. When a port restarts its pointer, it goes to address zero. If block addressing is also requested, it goes to the first word of the block named on that port's block-select input. Block addressing exists only during a restart. A write-protect input lets the writer skip over stored words: the pointer still advances, but the word is left as it was. The array is a behavioural dual-clock RAM with a registered read output.

Top module: `fmem_block_store`

## Requirements
- R1: Each enabled write-clock edge with protect low stores the 12-bit input word at the current write address. An enabled read-clock edge later returns that word from the same address.
- R2: A pointer steps by exactly one address on each clock edge where its enable is high. It holds while its enable is low.
- R3: A pointer at address NUM_BLOCKS*40-1 steps to address 0.
- R4: A pointer restart with block addressing low loads address 0, whatever the block-select value.
- R5: A pointer restart with block addressing high and block-select below NUM_BLOCKS loads block-select × 40.
- R6: A pointer restart with block addressing high and block-select at or above NUM_BLOCKS loads address 0.
- R7: Restart takes priority over enable on the same edge. That edge neither writes nor reads, and the read output keeps its value.
- R8: With write-protect high on an enabled write edge, the stored word at the current address is unchanged and the write pointer still advances by one.
- R9: Read data is registered on the enabled read-clock edge and visible in the following read cycle. It holds its value while read enable is low.
- R10: Reading is non-destructive: rereading the same addresses returns the same words until they are written again.
- R11: Synchronous active-high port resets clear that port's pointer to 0. The read-side reset also clears the read output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high write-side reset |
| wr_en | input | 1 | Write one word and advance the write pointer |
| wr_restart | input | 1 | Restart the write pointer |
| wr_blk_mode | input | 1 | On restart, load the start of the selected block |
| wr_blk_sel | input | SEL_W | Block number used by a block restart of the write pointer |
| wr_protect | input | 1 | Leave the addressed word unchanged on this write |
| wr_data | input | 12 | Word to be stored |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high read-side reset |
| rd_en | input | 1 | Read one word and advance the read pointer |
| rd_restart | input | 1 | Restart the read pointer |
| rd_blk_mode | input | 1 | On restart, load the start of the selected block |
| rd_blk_sel | input | SEL_W | Block number used by a block restart of the read pointer |
| rd_data | output | 12 | Registered read word |

## Verification
The checks on the pointers and the read register assume that each port's controls are synchronous to that port's own clock. They also assume a word is never read in the same moment it is being written through the other port, since a crossing-clock collision has no defined result. The stimulus changes every input on the falling edge of its own port's clock and samples the output just after the rising edge. It finishes all writes before reading back the affected addresses.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

    localparam int WORD_W  = 12;
    localparam int BLK_LEN = 40;

    typedef logic [WORD_W-1:0] word_t;

    // Per-port control bundle sampled on that port's clock
    typedef struct packed {
        logic en;
        logic restart;
        logic blk_mode;
    } port_ctl_t;

    // Start address for a restart: block base when selected and valid, else zero
    function automatic int unsigned restart_addr(input logic blk_mode,
                                                 input int unsigned sel,
                                                 input int unsigned n_blocks);
        if (blk_mode && (sel < n_blocks))
            return sel * BLK_LEN;
        return 0;
    endfunction

    // Increment with wrap at the end of the array
    function automatic int unsigned step_addr(input int unsigned a,
                                              input int unsigned depth);
        if (a >= depth - 1)
            return 0;
        return a + 1;
    endfunction

endpackage

// File: rtl/fmem_ptr.sv
module fmem_ptr
    import fmem_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int SEL_W      = $clog2(NUM_BLOCKS) + 1,
    parameter int DEPTH      = NUM_BLOCKS * BLK_LEN,
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ctl_t        ctl,
    input  logic [SEL_W-1:0] blk_sel,
    output logic [AW-1:0]    addr,
    output logic             access
);

    logic [AW-1:0] load_val;
    logic [AW-1:0] next_val;

    always_comb begin
        load_val = AW'(restart_addr(ctl.blk_mode, int'(blk_sel), NUM_BLOCKS));
        next_val = AW'(step_addr(int'(addr), DEPTH));
        access   = ctl.en && !ctl.restart;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (ctl.restart)
            addr <= load_val;
        else if (ctl.en)
            addr <= next_val;
    end

    // R3: the pointer never leaves the array
    p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        int'(addr) < DEPTH);

    // R2: no enable, no restart -> pointer holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !ctl.restart) |=> $stable(addr));

    // R3: last address steps to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.restart && int'(addr) == DEPTH - 1) |=> (addr == '0));

    // R5: valid block restart lands on the block base
    p_blk_load_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.restart && ctl.blk_mode && int'(blk_sel) < NUM_BLOCKS)
        |=> (int'(addr) == int'($past(blk_sel)) * BLK_LEN));

    // R4 / R6: plain restart or out-of-range block lands on zero
    p_zero_load_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.restart && (!ctl.blk_mode || int'(blk_sel) >= NUM_BLOCKS))
        |=> (addr == '0));

    // R11: reset clears the pointer
    p_rst_clear_r11: assert property (@(posedge clk)
        rst |=> (addr == '0));

endmodule

// File: rtl/fmem_ram.sv
module fmem_ram
    import fmem_pkg::*;
#(
    parameter int DEPTH = 640,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end

    // R9: output register holds while no read is issued
    p_rdata_hold_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !re |=> $stable(rdata));

    // R11: read-side reset clears the output word
    p_rdata_clear_r11: assert property (@(posedge rd_clk)
        rd_rst |=> (rdata == '0));

endmodule

// File: rtl/fmem_block_store.sv
module fmem_block_store
    import fmem_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int SEL_W      = $clog2(NUM_BLOCKS) + 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic             wr_restart,
    input  logic             wr_blk_mode,
    input  logic [SEL_W-1:0] wr_blk_sel,
    input  logic             wr_protect,
    input  logic [11:0]      wr_data,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    input  logic             rd_restart,
    input  logic             rd_blk_mode,
    input  logic [SEL_W-1:0] rd_blk_sel,
    output logic [11:0]      rd_data
);

    localparam int DEPTH  = NUM_BLOCKS * BLK_LEN;
    localparam int AW     = $clog2(DEPTH);
    localparam int NPORTS = 2;   // index 0 = write side, 1 = read side

    logic             p_clk    [NPORTS];
    logic             p_rst    [NPORTS];
    port_ctl_t        p_ctl    [NPORTS];
    logic [SEL_W-1:0] p_sel    [NPORTS];
    logic [AW-1:0]    p_addr   [NPORTS];
    logic             p_access [NPORTS];

    always_comb begin
        p_clk[0] = wr_clk;
        p_rst[0] = wr_rst;
        p_ctl[0] = '{en: wr_en, restart: wr_restart, blk_mode: wr_blk_mode};
        p_sel[0] = wr_blk_sel;
        p_clk[1] = rd_clk;
        p_rst[1] = rd_rst;
        p_ctl[1] = '{en: rd_en, restart: rd_restart, blk_mode: rd_blk_mode};
        p_sel[1] = rd_blk_sel;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_ptr
        fmem_ptr #(
            .NUM_BLOCKS(NUM_BLOCKS),
            .SEL_W     (SEL_W),
            .DEPTH     (DEPTH),
            .AW        (AW)
        ) u_ptr (
            .clk    (p_clk[g]),
            .rst    (p_rst[g]),
            .ctl    (p_ctl[g]),
            .blk_sel(p_sel[g]),
            .addr   (p_addr[g]),
            .access (p_access[g])
        );
    end

    logic  mem_we;
    word_t mem_rdata;

    assign mem_we = p_access[0] && !wr_protect;

    fmem_ram #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_ram (
        .wr_clk(wr_clk),
        .we    (mem_we),
        .waddr (p_addr[0]),
        .wdata (wr_data),
        .rd_clk(rd_clk),
        .rd_rst(rd_rst),
        .re    (p_access[1]),
        .raddr (p_addr[1]),
        .rdata (mem_rdata)
    );

    assign rd_data = mem_rdata;

    // R7: a read-side restart edge leaves the output word untouched
    p_restart_no_read_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_restart |=> $stable(rd_data));

    // R8: a protected write still moves the write pointer
    p_protect_advance_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_restart && wr_protect && int'(p_addr[0]) < DEPTH - 1)
        |=> (p_addr[0] == $past(p_addr[0]) + 1'b1));

endmodule

// File: tb/fmem_block_store_tb_top.sv
`timescale 1ns/1ps
module fmem_block_store_tb_top;

    localparam int NB    = 4;
    localparam int SEL_W = $clog2(NB) + 1;
    localparam int DEPTH = NB * 40;

    logic             wr_clk = 0, rd_clk = 0;
    logic             wr_rst, wr_en, wr_restart, wr_blk_mode, wr_protect;
    logic [SEL_W-1:0] wr_blk_sel;
    logic [11:0]      wr_data;
    logic             rd_rst, rd_en, rd_restart, rd_blk_mode;
    logic [SEL_W-1:0] rd_blk_sel;
    logic [11:0]      rd_data;

    int checks = 0, failures = 0;
    bit done = 0;

    fmem_block_store #(.NUM_BLOCKS(NB), .SEL_W(SEL_W)) dut_i (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_restart(wr_restart),
        .wr_blk_mode(wr_blk_mode), .wr_blk_sel(wr_blk_sel), .wr_protect(wr_protect),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_restart(rd_restart), .rd_blk_mode(rd_blk_mode), .rd_blk_sel(rd_blk_sel),
        .rd_data(rd_data)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    // Read-restart vectors: {block select, block mode, expected start address}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 0}, '{2, 0, 0}, '{1, 1, 40}, '{3, 1, 120},
        '{2, 1, 80}, '{4, 1, 0}, '{7, 1, 0}, '{1, 1, 40}
    };

    function automatic logic [11:0] pat(input int a);
        return 12'((a * 37 + 5) & 12'hFFF);
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_cyc(input bit en, input bit rs, input bit mode,
                          input int sel, input bit prot, input logic [11:0] d);
        @(negedge wr_clk);
        wr_en = en; wr_restart = rs; wr_blk_mode = mode;
        wr_blk_sel = SEL_W'(sel); wr_protect = prot; wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_en = 0; wr_restart = 0; wr_protect = 0;
    endtask

    task automatic rd_cyc(input bit en, input bit rs, input bit mode,
                          input int sel, output logic [11:0] q);
        @(negedge rd_clk);
        rd_en = en; rd_restart = rs; rd_blk_mode = mode; rd_blk_sel = SEL_W'(sel);
        @(posedge rd_clk);
        #1;
        q = rd_data;
        rd_en = 0; rd_restart = 0;
    endtask

    task automatic read_at(input int addr, output logic [11:0] q);
        rd_cyc(0, 1, 1, addr / 40, q);
        for (int i = 0; i < addr % 40; i++) rd_cyc(1, 0, 0, 0, q);
        rd_cyc(1, 0, 0, 0, q);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] q, prev;
        wr_rst = 1; rd_rst = 1;
        wr_en = 0; wr_restart = 0; wr_blk_mode = 0; wr_blk_sel = '0;
        wr_protect = 0; wr_data = '0;
        rd_en = 0; rd_restart = 0; rd_blk_mode = 0; rd_blk_sel = '0;
        repeat (3) @(posedge wr_clk);
        #7;
        chk("R11 reset output", rd_data, 12'h000);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;

        // R1/R2: fill the whole array sequentially from address 0
        for (int a = 0; a < DEPTH; a++) wr_cyc(1, 0, 0, 0, 0, pat(a));

        // R1/R4/R5/R6/R10: table of read restarts, three words each
        for (int v = 0; v < NVEC; v++) begin
            rd_cyc(0, 1, VEC[v][1] != 0, VEC[v][0], q);
            for (int k = 0; k < 3; k++) begin
                rd_cyc(1, 0, 0, 0, q);
                chk($sformatf("R5 R4 R6 R1 vec%0d word%0d", v, k), q, pat(VEC[v][2] + k));
            end
        end

        // R3: read block 3 through its end and across the wrap
        rd_cyc(0, 1, 1, 3, q);
        for (int k = 0; k < 40; k++) rd_cyc(1, 0, 0, 0, q);
        chk("R3 last address", q, pat(DEPTH - 1));
        rd_cyc(1, 0, 0, 0, q);
        chk("R3 wrap to zero", q, pat(0));

        // R10: reread block 0 gives the same words again
        rd_cyc(0, 1, 0, 0, q);
        rd_cyc(1, 0, 0, 0, q);
        chk("R10 reread word0", q, pat(0));
        rd_cyc(1, 0, 0, 0, q);
        chk("R10 reread word1", q, pat(1));

        // R9: output holds while read enable is low
        prev = q;
        rd_cyc(0, 0, 0, 0, q);
        rd_cyc(0, 0, 0, 0, q);
        chk("R9 hold while idle", q, prev);

        // R8: protected write at 40 keeps old word, pointer moves to 41
        wr_cyc(0, 1, 1, 1, 0, 12'h000);
        wr_cyc(1, 0, 0, 0, 1, 12'hABC);
        wr_cyc(1, 0, 0, 0, 0, 12'h123);
        read_at(40, q);
        chk("R8 protected word unchanged", q, pat(40));
        rd_cyc(1, 0, 0, 0, q);
        chk("R8 pointer advanced", q, 12'h123);

        // R2: write pointer holds across idle write cycles
        wr_cyc(0, 1, 1, 2, 0, 12'h000);
        wr_cyc(1, 0, 0, 0, 0, 12'h111);
        wr_cyc(0, 0, 0, 0, 0, 12'hEEE);
        wr_cyc(0, 0, 0, 0, 0, 12'hEEE);
        wr_cyc(1, 0, 0, 0, 0, 12'h222);
        read_at(80, q);
        chk("R2 first write", q, 12'h111);
        rd_cyc(1, 0, 0, 0, q);
        chk("R2 held pointer", q, 12'h222);
        rd_cyc(1, 0, 0, 0, q);
        chk("R2 next untouched", q, pat(82));

        // R7: restart with enable high does not write at the old pointer (82)
        wr_cyc(1, 1, 1, 3, 0, 12'h777);
        wr_cyc(1, 0, 0, 0, 0, 12'h555);
        read_at(82, q);
        chk("R7 no write on restart edge", q, pat(82));
        read_at(120, q);
        chk("R7 write after restart", q, 12'h555);
        prev = q;
        rd_cyc(1, 1, 0, 0, q);
        chk("R7 no read on restart edge", q, prev);
        rd_cyc(1, 0, 0, 0, q);
        chk("R7 read after restart at 0", q, pat(0));

        // R11: write-side reset returns the write pointer to 0
        @(negedge wr_clk); wr_rst = 1;
        @(negedge wr_clk); wr_rst = 0;
        wr_cyc(1, 0, 0, 0, 0, 12'h999);
        read_at(0, q);
        chk("R11 write pointer reset", q, 12'h999);

        // R11: read-side reset clears output and pointer
        @(negedge rd_clk); rd_rst = 1;
        @(posedge rd_clk); #1;
        chk("R11 read reset clears output", rd_data, 12'h000);
        @(negedge rd_clk); rd_rst = 0;
        rd_cyc(1, 0, 0, 0, q);
        chk("R11 read pointer reset", q, 12'h999);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule